// File: doc/BRIEF.md
# Debug Trigger Register File

This block holds the machine-mode configuration of two hardware debug triggers. Both are address/data-match triggers. Software reaches them through a small CSR port. A selector register picks one trigger, and data registers then show the control word and the compare address of the trigger it picks. Every write to a control word is legalized before it is stored. The trigger type is pinned to the address/data-match code, the debug-mode bit is held clear, features that are not built read back as zero, and an unsupported access-size code is replaced by "any size".

The stored control and compare values of each trigger leave the block on dedicated output buses, where a separate match unit uses them. Whenever a write really changes a trigger's stored control or address value, that trigger's re-arm output pulses for one cycle so the match unit can reload it. The register width is a parameter and may be 32 or 64.

Top module: `dbg_trig_regs`

## Requirements
- R1: After reset the selector reads 0, each trigger's compare address reads 0, and each control word reads with only the type field set: 0x2000_0000 when the width is 32, 0x2000_0000_0000_0000 when it is 64.
- R2: The CSR port decodes `csr_sel` as follows: 0 is the selector, 1 is the control word of the selected trigger, 2 is its compare address, and 3 is a third data register. `csr_rdata` is combinational. The selector keeps every bit written to it and reads it back unchanged.
- R3: A control write always stores 2 in the type field and 0 in the debug-mode bit, whatever those bits carried. With a width of 32 the type field is bits 31:28 and the debug-mode bit is bit 27. With a width of 64 they are bits 63:60 and bit 59.
- R4: Every control bit outside the type field, the mode and access enables, and the size field is stored as zero.
- R5: The mode enables (M at bit 6, S at bit 4, U at bit 3) and the access enables (execute at bit 2, store at bit 1, load at bit 0) are stored exactly as written.
- R6: The size field is built from a low part at bits 17:16 and, with a width of 64 only, a high part at bits 22:21. The code is high×4 + low. Codes 0, 1, 2, 3 and 5 are kept as written. Any other code stores both parts as zero.
- R7: A write to the compare address register stores all bits of the written value.
- R8: When the selector holds a value of 2 or more, writes to the control and compare registers change nothing, and reads of them return 0.
- R9: The third data register reads 0 for any trigger, and writes to it change nothing.
- R10: `trig_rearm_o[i]` is high for exactly the one cycle after a clock edge at which trigger i's stored control or address value changed. A write that stores the value already held does not raise it.
- R11: `trig_ctrl_o[i]` and `trig_addr_o[i]` always show trigger i's stored values. Writes to one trigger leave the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_we | input | 1 | Write strobe for the register chosen by csr_sel |
| csr_sel | input | 2 | Register select: 0 selector, 1 control, 2 compare address, 3 third data register |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data of the register chosen by csr_sel |
| trig_ctrl_o | output | NUM_TRIG×XLEN | Stored control word of each trigger |
| trig_addr_o | output | NUM_TRIG×XLEN | Stored compare address of each trigger |
| trig_rearm_o | output | NUM_TRIG | One-cycle pulse when a trigger's stored values change |

## Verification
The bench writes all-ones to a control word. That write shows whether the type and debug-mode bits are forced, and whether every bit that is not built is dropped. A design that passed raw bits through would read back values outside the legal mask. A 64-bit instance is given size codes 4, 5, 6 and 15. A design that judged legality from the low part alone would keep code 4 or code 6, and one that ignored the high part would lose code 5. The selector is also set to 2 and to a value with only the top bit set. A design that decoded only the low selector bits would then write trigger 0 by mistake. Finally, the bench repeats writes whose legal value is unchanged. A design that pulsed on every write, rather than on a real change, would raise a spurious re-arm.

// File: rtl/dbg_trig_pkg.sv
// Shared constants for the debug trigger register file.
// Assumes the standard address/data-match control layout in its low bits.
package dbg_trig_pkg;

    // CSR port register decode
    typedef enum logic [1:0] {
        CSR_SELECT = 2'd0,
        CSR_CTRL   = 2'd1,
        CSR_CMP    = 2'd2,
        CSR_EXTRA  = 2'd3
    } csr_sel_e;

    localparam logic [3:0]  TYPE_ADDR_MATCH = 4'd2;
    // mode enables M(6) S(4) U(3), access enables X(2) W(1) R(0)
    localparam logic [63:0] KEEP_BITS       = 64'h5F;
    localparam int          SIZELO_LSB      = 16;
    localparam int          SIZEHI_LSB      = 21;

endpackage

// File: rtl/dbg_trig_legalize.sv
// Turns a raw control write into the value that may be stored.
// Assumes XLEN is 32 or 64. Purely combinational.
module dbg_trig_legalize #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] raw_i,
    output logic [XLEN-1:0] legal_o
);
    import dbg_trig_pkg::*;

    localparam bit WIDE = (XLEN == 64);

    logic [3:0] size_code;
    logic       size_ok;

    // Build the full size code; the high part only exists in the wide variant.
    always_comb begin
        size_code = {(WIDE ? raw_i[SIZEHI_LSB+1:SIZEHI_LSB] : 2'b00),
                     raw_i[SIZELO_LSB+1:SIZELO_LSB]};
        size_ok   = (size_code <= 4'd3) || (size_code == 4'd5);
    end

    // Assemble the legal value: fixed type, clear dmode, kept enables, checked size.
    always_comb begin
        legal_o = raw_i & XLEN'(KEEP_BITS);
        legal_o[XLEN-1:XLEN-4] = TYPE_ADDR_MATCH;
        if (size_ok) begin
            legal_o[SIZELO_LSB+1:SIZELO_LSB] = raw_i[SIZELO_LSB+1:SIZELO_LSB];
            if (WIDE) begin
                legal_o[SIZEHI_LSB+1:SIZEHI_LSB] = raw_i[SIZEHI_LSB+1:SIZEHI_LSB];
            end
        end
    end

endmodule

// File: rtl/dbg_trig_slot.sv
// Storage for one trigger: control word, compare address and re-arm pulse.
// Assumes the control input is already legalized. Synchronous active-low reset.
module dbg_trig_slot #(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] CTRL_RST = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_ctrl_i,
    input  logic            wr_cmp_i,
    input  logic [XLEN-1:0] ctrl_i,
    input  logic [XLEN-1:0] cmp_i,
    output logic [XLEN-1:0] ctrl_q,
    output logic [XLEN-1:0] cmp_q,
    output logic            rearm_q
);
    logic ctrl_chg;
    logic cmp_chg;

    // Detect writes that actually alter stored state.
    always_comb begin
        ctrl_chg = wr_ctrl_i && (ctrl_i != ctrl_q);
        cmp_chg  = wr_cmp_i  && (cmp_i  != cmp_q);
    end

    // Hold the trigger registers and register the change pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= CTRL_RST;
            cmp_q   <= '0;
            rearm_q <= 1'b0;
        end else begin
            if (ctrl_chg) ctrl_q <= ctrl_i;
            if (cmp_chg)  cmp_q  <= cmp_i;
            rearm_q <= ctrl_chg || cmp_chg;
        end
    end

endmodule

// File: rtl/dbg_trig_regs.sv
// Machine-mode debug trigger register file: a selector plus per-trigger
// control and compare registers behind one CSR port. Assumes XLEN is 32 or 64
// and that the CSR port issues at most one write per cycle.
module dbg_trig_regs #(
    parameter int XLEN     = 32,
    parameter int NUM_TRIG = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           csr_we,
    input  logic [1:0]                     csr_sel,
    input  logic [XLEN-1:0]                csr_wdata,
    output logic [XLEN-1:0]                csr_rdata,
    output logic [NUM_TRIG-1:0][XLEN-1:0]  trig_ctrl_o,
    output logic [NUM_TRIG-1:0][XLEN-1:0]  trig_addr_o,
    output logic [NUM_TRIG-1:0]            trig_rearm_o
);
    import dbg_trig_pkg::*;

    localparam logic [XLEN-1:0] CTRL_RST = XLEN'(TYPE_ADDR_MATCH) << (XLEN - 4);

    csr_sel_e              sel_dec;
    logic [XLEN-1:0]       sel_q;
    logic [XLEN-1:0]       ctrl_legal;
    logic [NUM_TRIG-1:0]   slot_hit;

    assign sel_dec = csr_sel_e'(csr_sel);

    // Selector register keeps the full written word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (csr_we && sel_dec == CSR_SELECT) begin
            sel_q <= csr_wdata;
        end
    end

    dbg_trig_legalize #(.XLEN(XLEN)) u_legal (
        .raw_i   (csr_wdata),
        .legal_o (ctrl_legal)
    );

    for (genvar i = 0; i < NUM_TRIG; i++) begin : g_slot
        assign slot_hit[i] = (sel_q == XLEN'(i));

        dbg_trig_slot #(.XLEN(XLEN), .CTRL_RST(CTRL_RST)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_ctrl_i (csr_we && sel_dec == CSR_CTRL && slot_hit[i]),
            .wr_cmp_i  (csr_we && sel_dec == CSR_CMP  && slot_hit[i]),
            .ctrl_i    (ctrl_legal),
            .cmp_i     (csr_wdata),
            .ctrl_q    (trig_ctrl_o[i]),
            .cmp_q     (trig_addr_o[i]),
            .rearm_q   (trig_rearm_o[i])
        );
    end

    // Read mux; unknown triggers and the third data register read zero.
    always_comb begin
        csr_rdata = '0;
        case (sel_dec)
            CSR_SELECT: csr_rdata = sel_q;
            CSR_CTRL: begin
                for (int i = 0; i < NUM_TRIG; i++) begin
                    if (slot_hit[i]) csr_rdata = trig_ctrl_o[i];
                end
            end
            CSR_CMP: begin
                for (int i = 0; i < NUM_TRIG; i++) begin
                    if (slot_hit[i]) csr_rdata = trig_addr_o[i];
                end
            end
            default: csr_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dbg_trig_regs_chk.sv
// Property checker for dbg_trig_regs, attached to every instance by bind.
module dbg_trig_regs_chk #(
    parameter int XLEN     = 32,
    parameter int NUM_TRIG = 2
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          csr_we,
    input logic [1:0]                    csr_sel,
    input logic [XLEN-1:0]               csr_wdata,
    input logic [XLEN-1:0]               sel_q,
    input logic [NUM_TRIG-1:0][XLEN-1:0] trig_ctrl_o,
    input logic [NUM_TRIG-1:0][XLEN-1:0] trig_addr_o,
    input logic [NUM_TRIG-1:0]           trig_rearm_o
);
    localparam logic [XLEN-1:0] KEEP    = XLEN'(64'h5F);
    localparam logic [XLEN-1:0] SIZE_M  = (XLEN == 64) ? XLEN'(64'h63_0000) : XLEN'(64'h3_0000);
    localparam logic [XLEN-1:0] TYPE_M  = XLEN'(64'hF) << (XLEN - 4);
    localparam logic [XLEN-1:0] ALLOWED = KEEP | SIZE_M | TYPE_M;

    for (genvar i = 0; i < NUM_TRIG; i++) begin : g_t
        // R3: stored type is 2 and dmode is clear
        a_r3_type_fixed: assert property (@(posedge clk) disable iff (!rst_n)
            trig_ctrl_o[i][XLEN-1:XLEN-5] == 5'b00100);

        // R4: nothing outside the built fields is ever set
        a_r4_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (trig_ctrl_o[i] & ~ALLOWED) == '0);

        // R5: mode and access enables follow the written word
        a_r5_enables_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (csr_we && csr_sel == 2'd1 && sel_q == XLEN'(i)) |=>
            ((trig_ctrl_o[i] & KEEP) == ($past(csr_wdata) & KEEP)));

        // R8: writes with an out-of-range selector leave all triggers alone
        a_r8_oob_ignored: assert property (@(posedge clk) disable iff (!rst_n)
            (csr_we && csr_sel != 2'd0 && sel_q >= XLEN'(NUM_TRIG)) |=>
            ($stable(trig_ctrl_o[i]) && $stable(trig_addr_o[i]) && !trig_rearm_o[i]));

        // R10: a re-arm pulse always follows a real change
        a_r10_rearm_cause: assert property (@(posedge clk) disable iff (!rst_n)
            trig_rearm_o[i] |->
            ((trig_ctrl_o[i] != $past(trig_ctrl_o[i])) || (trig_addr_o[i] != $past(trig_addr_o[i]))));

        if (XLEN == 64) begin : g_wide
            // R6: an illegal size code is never stored
            a_r6_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
                !({trig_ctrl_o[i][22:21], trig_ctrl_o[i][17:16]} inside {4'd4, 4'd6, 4'd7,
                  4'd8, 4'd9, 4'd10, 4'd11, 4'd12, 4'd13, 4'd14, 4'd15}));
        end
    end

endmodule

bind dbg_trig_regs dbg_trig_regs_chk #(.XLEN(XLEN), .NUM_TRIG(NUM_TRIG)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .csr_we       (csr_we),
    .csr_sel      (csr_sel),
    .csr_wdata    (csr_wdata),
    .sel_q        (sel_q),
    .trig_ctrl_o  (trig_ctrl_o),
    .trig_addr_o  (trig_addr_o),
    .trig_rearm_o (trig_rearm_o)
);

// File: tb/dbg_trig_regs_bench.sv
// Directed bench: a 32-bit instance for most scenarios, a 64-bit one for sizes.
module dbg_trig_regs_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // 32-bit instance
    logic                 we = 1'b0;
    logic [1:0]           sel = '0;
    logic [31:0]          wdata = '0;
    logic [31:0]          rdata;
    logic [1:0][31:0]     ctrl_o, addr_o;
    logic [1:0]           rearm_o;

    dbg_trig_regs #(.XLEN(32), .NUM_TRIG(2)) u_dbg_trig_regs (
        .clk(clk), .rst_n(rst_n), .csr_we(we), .csr_sel(sel), .csr_wdata(wdata),
        .csr_rdata(rdata), .trig_ctrl_o(ctrl_o), .trig_addr_o(addr_o), .trig_rearm_o(rearm_o)
    );

    // 64-bit instance
    logic                 we64 = 1'b0;
    logic [1:0]           sel64 = '0;
    logic [63:0]          wdata64 = '0;
    logic [63:0]          rdata64;
    logic [1:0][63:0]     ctrl64_o, addr64_o;
    logic [1:0]           rearm64_o;

    dbg_trig_regs #(.XLEN(64), .NUM_TRIG(2)) u_dbg_trig_regs_w64 (
        .clk(clk), .rst_n(rst_n), .csr_we(we64), .csr_sel(sel64), .csr_wdata(wdata64),
        .csr_rdata(rdata64), .trig_ctrl_o(ctrl64_o), .trig_addr_o(addr64_o), .trig_rearm_o(rearm64_o)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr32(input logic [1:0] s, input logic [31:0] d, output logic [1:0] pulse);
        @(negedge clk);
        we = 1'b1; sel = s; wdata = d;
        @(negedge clk);
        we = 1'b0;
        pulse = rearm_o;
    endtask

    task automatic rd32(input logic [1:0] s, output logic [31:0] d);
        sel = s;
        #1;
        d = rdata;
    endtask

    task automatic wr64(input logic [1:0] s, input logic [63:0] d);
        @(negedge clk);
        we64 = 1'b1; sel64 = s; wdata64 = d;
        @(negedge clk);
        we64 = 1'b0;
    endtask

    task automatic rd64(input logic [1:0] s, output logic [63:0] d);
        sel64 = s;
        #1;
        d = rdata64;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        logic [63:0] q;
        rd32(2'd0, d); check("R1 selector", d, 32'h0);
        rd32(2'd1, d); check("R1 ctrl t0", d, 32'h2000_0000);
        rd32(2'd2, d); check("R1 addr t0", d, 32'h0);
        check("R1 ctrl t1 port", ctrl_o[1], 32'h2000_0000);
        check("R1 rearm", rearm_o, 2'b00);
        rd64(2'd1, q); check("R1 ctrl w64", q, 64'h2000_0000_0000_0000);
    endtask

    task automatic t_selector;
        logic [31:0] d;
        logic [1:0] p;
        wr32(2'd0, 32'hDEAD_BEEF, p);
        rd32(2'd0, d); check("R2 selector all bits", d, 32'hDEAD_BEEF);
        wr32(2'd0, 32'h0, p);
        rd32(2'd0, d); check("R2 selector back to 0", d, 32'h0);
    endtask

    task automatic t_ctrl_legal;
        logic [31:0] d;
        logic [1:0] p;
        wr32(2'd1, 32'hFFFF_FFFF, p);
        rd32(2'd1, d); check("R3 R4 all-ones ctrl", d, 32'h2003_005F);
        check("R10 pulse on change", p, 2'b01);
        check("R11 ctrl port t0", ctrl_o[0], 32'h2003_005F);
        wr32(2'd1, 32'h0000_0000, p);
        rd32(2'd1, d); check("R3 zero write keeps type", d, 32'h2000_0000);
        wr32(2'd1, 32'hE801_0049, p);
        rd32(2'd1, d); check("R5 enables and size", d, 32'h2001_0049);
    endtask

    task automatic t_addr;
        logic [31:0] d;
        logic [1:0] p;
        wr32(2'd0, 32'd1, p);
        wr32(2'd2, 32'h1234_5678, p);
        check("R10 pulse only t1", p, 2'b10);
        rd32(2'd2, d); check("R7 addr t1", d, 32'h1234_5678);
        check("R11 addr port t1", addr_o[1], 32'h1234_5678);
        check("R11 addr t0 untouched", addr_o[0], 32'h0);
        check("R11 ctrl t0 untouched", ctrl_o[0], 32'h2001_0049);
    endtask

    task automatic t_no_change;
        logic [1:0] p;
        wr32(2'd2, 32'h1234_5678, p);
        check("R10 same addr no pulse", p, 2'b00);
        wr32(2'd1, 32'hF000_0000, p);
        check("R10 legal-same ctrl no pulse", p, 2'b00);
        wr32(2'd1, 32'h0000_0004, p);
        check("R10 ctrl change pulse t1", p, 2'b10);
    endtask

    task automatic t_oob;
        logic [31:0] d;
        logic [1:0] p;
        wr32(2'd0, 32'd2, p);
        wr32(2'd1, 32'h0000_0041, p);
        check("R8 no pulse ctrl", p, 2'b00);
        wr32(2'd2, 32'hAAAA_5555, p);
        rd32(2'd1, d); check("R8 ctrl read zero", d, 32'h0);
        rd32(2'd2, d); check("R8 addr read zero", d, 32'h0);
        wr32(2'd0, 32'h8000_0000, p);
        wr32(2'd2, 32'h0BAD_0BAD, p);
        check("R8 high selector bit", addr_o[0], 32'h0);
        check("R8 t1 addr kept", addr_o[1], 32'h1234_5678);
        check("R8 t1 ctrl kept", ctrl_o[1], 32'h2000_0004);
    endtask

    task automatic t_extra;
        logic [31:0] d;
        logic [1:0] p;
        wr32(2'd0, 32'd0, p);
        wr32(2'd3, 32'hFFFF_FFFF, p);
        rd32(2'd3, d); check("R9 third reg reads zero", d, 32'h0);
        check("R9 no pulse", p, 2'b00);
        check("R9 ctrl t0 kept", ctrl_o[0], 32'h2001_0049);
    endtask

    task automatic t_size64;
        logic [63:0] q;
        wr64(2'd1, 64'h0000_0000_0021_0044);
        rd64(2'd1, q); check("R6 code 5 kept", q, 64'h2000_0000_0021_0044);
        wr64(2'd1, 64'h0000_0000_0020_0004);
        rd64(2'd1, q); check("R6 code 4 dropped", q, 64'h2000_0000_0000_0004);
        wr64(2'd1, 64'h0000_0000_0022_0001);
        rd64(2'd1, q); check("R6 code 6 dropped", q, 64'h2000_0000_0000_0001);
        wr64(2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
        rd64(2'd1, q); check("R3 R4 R6 all-ones w64", q, 64'h2000_0000_0000_005F);
        wr64(2'd1, 64'h0000_0000_0003_0008);
        rd64(2'd1, q); check("R6 code 3 kept w64", q, 64'h2000_0000_0003_0008);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_selector();
        t_ctrl_legal();
        t_addr();
        t_no_change();
        t_oob();
        t_extra();
        t_size64();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule